// File: doc/BRIEF.md
# ATA Task-File Register Block

This block is the device side of a legacy ATA register file. A host reaches it through two chip selects, a three-bit offset, single-cycle read and write strobes and a 16-bit data bus. The block decodes each host cycle, keeps the task-file state (feature, sector count, sector number, cylinder, head and device select), and passes those values to a simple drive core. It builds the status byte from the core's condition inputs and forwards the 16-bit data port to the core.

The block also holds the device-control register. This register can mask the interrupt line and can hold the core in software reset. The pending interrupt is set by a completion pulse from the core. A read of the primary status register clears it, and a read of the alternate status register leaves it alone. A write of a command raises a one-cycle strobe to the core that carries the command byte, unless the core reports busy.

All host strobes are sampled on the rising clock edge. Register writes become visible from the next cycle. Read data is combinational from the current selection.

Top module: `ata_taskfile`

## Requirements
- R1: Command-block registers respond only when `host_cs0`=1 and `host_cs1`=0. Control-block registers respond only when `host_cs1`=1 and `host_cs0`=0. With both selects high, or both low, a write changes nothing and a read returns 0000h.
- R2: After reset the block comes up as follows: sector count 01h, sector number 01h, cylinder 0, head 0, device 0, feature 00h, interrupt low, software reset low, and no command strobe.
- R3: Offsets 2, 3 and 4 (sector count, sector number, cylinder low) read back the full byte written. Offset 5 (cylinder high) keeps only bits 1..0 and reads the rest as 0. `tf_cylinder` equals {cylinder high[1:0], cylinder low}. All 8-bit registers read 00h in bits 15..8.
- R4: Offset 6 (head/device) stores bits 3..0 as the head and bit 4 as the device (0 = master, 1 = slave). Bits 7..5 are ignored on write and always read as 101b.
- R5: `tf_sec_index` equals the sector number register, except that a value of 00h reports 256.
- R6: A read of offset 1 returns {0, `core_fault_code`[6:0]}. The code bits are: 0 address mark missing, 1 track 0 missing, 2 aborted, 3 media change requested, 4 ID missing, 5 media changed, 6 uncorrectable. A write of offset 1 loads `tf_feature`.
- R7: A read of offset 7 (primary status) and a read of control offset 6 (alternate status) both return the byte {busy, ready, write fault, seek done, data request, corrected, index, error}, listed from bit 7 down to bit 0.
- R8: A `core_done` pulse sets a pending interrupt. A primary status read clears it, unless `core_done` is high in the same cycle. An alternate status read does not clear it.
- R9: Writing control offset 6 with bit 1 = 1 holds `intrq` low while keeping the pending interrupt. Writing bit 1 back to 0 lets a still-pending interrupt drive `intrq` high again.
- R10: Writing control offset 6 with bit 2 = 1 raises `soft_reset`. It stays high until that bit is written as 0, and the pending interrupt is held clear while it is high.
- R11: A write of offset 7 while `core_busy`=0 raises `cmd_valid` for exactly one cycle, starting the cycle after the write, with `cmd_code` equal to the written byte. While `core_busy`=1 the write is ignored.
- R12: A read of control offset 7 returns: bit 0 = not device, bit 1 = device, bits 5..2 = inverted head, bit 6 = `core_writing`, bit 7 = 0. Writes to this offset change nothing.
- R13: A read of offset 0 returns the full 16-bit `core_rdata` and pulses `dp_rd` in the same cycle. A write of offset 0 pulses `dp_wr` in the same cycle, with `dp_wdata` equal to the host word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs0 | input | 1 | Command-block select, active high |
| host_cs1 | input | 1 | Control-block select, active high |
| host_addr | input | 3 | Register offset |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| core_busy | input | 1 | Core busy |
| core_ready | input | 1 | Core ready |
| core_drq | input | 1 | Core data request |
| core_err | input | 1 | Core error flag |
| core_wfault | input | 1 | Core write fault |
| core_seek_ok | input | 1 | Core seek complete |
| core_corrected | input | 1 | Core corrected data |
| core_index | input | 1 | Core index pulse |
| core_fault_code | input | 7 | Core error detail bits |
| core_writing | input | 1 | Core write in progress |
| core_done | input | 1 | Command completion pulse |
| core_rdata | input | 16 | Core data-port word |
| tf_feature | output | 8 | Feature register |
| tf_sec_count | output | 8 | Sector count register |
| tf_sec_index | output | 9 | Sector number, 1..256 |
| tf_cylinder | output | 10 | Cylinder number |
| tf_head | output | 4 | Head number |
| tf_dev | output | 1 | Device select |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Command byte |
| dp_rd | output | 1 | Data-port read pulse |
| dp_wr | output | 1 | Data-port write pulse |
| dp_wdata | output | 16 | Data-port write word |
| intrq | output | 1 | Device interrupt |
| soft_reset | output | 1 | Software reset level |

## Verification
The assertions assume the following about the inputs:
- `host_rd` and `host_wr` are never high in the same cycle.
- `core_done` comes as a single-cycle pulse.
- The core status inputs are steady while a status read is in flight.

The bench keeps to these rules. It drives each access as a one-cycle strobe set at the falling edge, drives reads and writes in separate cycles, and changes core inputs only between accesses. Same-cycle cases are built on purpose: a completion that coincides with a primary status read, and writes made with both selects high. These check the ordering rules without breaking the rules above.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_ERRFEAT, SEL_SCNT, SEL_SNUM, SEL_CYLL,
    SEL_CYLH, SEL_HDEV, SEL_STCMD, SEL_ALTDC, SEL_DRVADR
  } tf_sel_e;

  typedef struct packed {
    logic we_data;
    logic we_feat;
    logic we_scnt;
    logic we_snum;
    logic we_cyll;
    logic we_cylh;
    logic we_hdev;
    logic we_cmd;
    logic we_dctl;
    logic re_data;
    logic re_stat;
    logic re_alt;
  } tf_strobe_t;

  // Register selection from the two selects and the offset.
  function automatic tf_sel_e tf_decode(logic cs0, logic cs1, logic [2:0] a);
    tf_sel_e s;
    s = SEL_NONE;
    if (cs0 && !cs1) begin
      case (a)
        3'd0: s = SEL_DATA;
        3'd1: s = SEL_ERRFEAT;
        3'd2: s = SEL_SCNT;
        3'd3: s = SEL_SNUM;
        3'd4: s = SEL_CYLL;
        3'd5: s = SEL_CYLH;
        3'd6: s = SEL_HDEV;
        default: s = SEL_STCMD;
      endcase
    end else if (cs1 && !cs0) begin
      if (a == 3'd6) s = SEL_ALTDC;
      else if (a == 3'd7) s = SEL_DRVADR;
    end
    return s;
  endfunction

  // Sector numbering runs 1..256; a stored zero stands for 256.
  function automatic logic [8:0] sector_index(logic [7:0] v);
    return (v == 8'h00) ? 9'd256 : {1'b0, v};
  endfunction

  function automatic logic [7:0] status_byte(logic busy, logic ready, logic wf,
                                             logic seek, logic drq, logic corr,
                                             logic idx, logic err);
    return {busy, ready, wf, seek, drq, corr, idx, err};
  endfunction

  function automatic logic [7:0] hdev_byte(logic dev, logic [3:0] head);
    return {3'b101, dev, head};
  endfunction

  function automatic logic [7:0] drive_addr_byte(logic dev, logic [3:0] head,
                                                 logic writing);
    return {1'b0, writing, ~head, dev, ~dev};
  endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
(
  input  logic       cs0,
  input  logic       cs1,
  input  logic [2:0] addr,
  input  logic       rd,
  input  logic       wr,
  output tf_sel_e    sel,
  output tf_strobe_t stb
);

  always_comb begin
    sel         = tf_decode(cs0, cs1, addr);
    stb         = '0;
    stb.we_data = wr && (sel == SEL_DATA);
    stb.we_feat = wr && (sel == SEL_ERRFEAT);
    stb.we_scnt = wr && (sel == SEL_SCNT);
    stb.we_snum = wr && (sel == SEL_SNUM);
    stb.we_cyll = wr && (sel == SEL_CYLL);
    stb.we_cylh = wr && (sel == SEL_CYLH);
    stb.we_hdev = wr && (sel == SEL_HDEV);
    stb.we_cmd  = wr && (sel == SEL_STCMD);
    stb.we_dctl = wr && (sel == SEL_ALTDC);
    stb.re_data = rd && (sel == SEL_DATA);
    stb.re_stat = rd && (sel == SEL_STCMD);
    stb.re_alt  = rd && (sel == SEL_ALTDC);
  end

endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs #(
  parameter int CYL_HI_W = 2,
  localparam int CYL_W   = 8 + CYL_HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_feat,
  input  logic             we_scnt,
  input  logic             we_snum,
  input  logic             we_cyll,
  input  logic             we_cylh,
  input  logic             we_hdev,
  input  logic             we_cmd,
  input  logic [7:0]       wbyte,
  input  logic             core_busy,
  output logic [7:0]       feature,
  output logic [7:0]       sec_count,
  output logic [7:0]       sec_num,
  output logic [CYL_W-1:0] cylinder,
  output logic [3:0]       head,
  output logic             dev,
  output logic             cmd_valid,
  output logic [7:0]       cmd_code
);

  logic cmd_accept;
  assign cmd_accept = we_cmd && !core_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feature   <= 8'h00;
      sec_count <= 8'h01;
      sec_num   <= 8'h01;
      cylinder  <= '0;
      head      <= 4'h0;
      dev       <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_code  <= 8'h00;
    end else begin
      if (we_feat) feature   <= wbyte;
      if (we_scnt) sec_count <= wbyte;
      if (we_snum) sec_num   <= wbyte;
      if (we_cyll) cylinder[7:0] <= wbyte;
      if (we_cylh) cylinder[CYL_W-1:8] <= wbyte[CYL_HI_W-1:0];
      if (we_hdev) begin
        head <= wbyte[3:0];
        dev  <= wbyte[4];
      end
      cmd_valid <= cmd_accept;
      if (cmd_accept) cmd_code <= wbyte;
    end
  end

  // R11: a command strobe only follows a cycle in which the core was idle
  p_cmd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(core_busy));

  // R11: a write while busy never produces a strobe
  p_cmd_busy_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we_cmd && core_busy) |=> !cmd_valid);

endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_dctl,
  input  logic [1:0] dctl_bits,
  input  logic       st_rd,
  input  logic       core_done,
  output logic       nien,
  output logic       srst,
  output logic       pending,
  output logic       intrq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nien    <= 1'b0;
      srst    <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (we_dctl) begin
        nien <= dctl_bits[0];
        srst <= dctl_bits[1];
      end
      if (srst)           pending <= 1'b0;
      else if (core_done) pending <= 1'b1;
      else if (st_rd)     pending <= 1'b0;
    end
  end

  assign intrq = pending && !nien;

  // R8: the pending interrupt only rises after a completion pulse
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(core_done));

  // R8: a primary status read with no coincident completion clears it
  p_status_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !core_done) |=> !pending);

  // R10: the reset level only moves on a device-control write
  p_srst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_dctl |=> $stable(srst));

  // R10: software reset keeps the interrupt clear
  p_srst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !pending);

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CYL_HI_W = 2,
  localparam int CYL_W   = 8 + CYL_HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_cs0,
  input  logic             host_cs1,
  input  logic [2:0]       host_addr,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             core_busy,
  input  logic             core_ready,
  input  logic             core_drq,
  input  logic             core_err,
  input  logic             core_wfault,
  input  logic             core_seek_ok,
  input  logic             core_corrected,
  input  logic             core_index,
  input  logic [6:0]       core_fault_code,
  input  logic             core_writing,
  input  logic             core_done,
  input  logic [DW-1:0]    core_rdata,
  output logic [7:0]       tf_feature,
  output logic [7:0]       tf_sec_count,
  output logic [8:0]       tf_sec_index,
  output logic [CYL_W-1:0] tf_cylinder,
  output logic [3:0]       tf_head,
  output logic             tf_dev,
  output logic             cmd_valid,
  output logic [7:0]       cmd_code,
  output logic             dp_rd,
  output logic             dp_wr,
  output logic [DW-1:0]    dp_wdata,
  output logic             intrq,
  output logic             soft_reset
);

  tf_sel_e    sel;
  tf_strobe_t stb;
  logic [7:0] sec_num;
  logic [7:0] stat;
  logic [7:0] byte_q;
  logic       nien;
  logic       irq_pending;

  ata_tf_decode u_dec (
    .cs0 (host_cs0), .cs1 (host_cs1), .addr (host_addr),
    .rd  (host_rd),  .wr  (host_wr),  .sel  (sel), .stb (stb)
  );

  ata_tf_regs #(.CYL_HI_W(CYL_HI_W)) u_regs (
    .clk       (clk),         .rst_n     (rst_n),
    .we_feat   (stb.we_feat), .we_scnt   (stb.we_scnt),
    .we_snum   (stb.we_snum), .we_cyll   (stb.we_cyll),
    .we_cylh   (stb.we_cylh), .we_hdev   (stb.we_hdev),
    .we_cmd    (stb.we_cmd),  .wbyte     (host_wdata[7:0]),
    .core_busy (core_busy),   .feature   (tf_feature),
    .sec_count (tf_sec_count),.sec_num   (sec_num),
    .cylinder  (tf_cylinder), .head      (tf_head),
    .dev       (tf_dev),      .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code)
  );

  ata_tf_ctrl u_ctrl (
    .clk       (clk),          .rst_n     (rst_n),
    .we_dctl   (stb.we_dctl),  .dctl_bits (host_wdata[2:1]),
    .st_rd     (stb.re_stat),  .core_done (core_done),
    .nien      (nien),         .srst      (soft_reset),
    .pending   (irq_pending),  .intrq     (intrq)
  );

  assign tf_sec_index = sector_index(sec_num);
  assign dp_rd        = stb.re_data;
  assign dp_wr        = stb.we_data;
  assign dp_wdata     = host_wdata;

  assign stat = status_byte(core_busy, core_ready, core_wfault, core_seek_ok,
                            core_drq, core_corrected, core_index, core_err);

  always_comb begin
    case (sel)
      SEL_ERRFEAT: byte_q = {1'b0, core_fault_code};
      SEL_SCNT:    byte_q = tf_sec_count;
      SEL_SNUM:    byte_q = sec_num;
      SEL_CYLL:    byte_q = tf_cylinder[7:0];
      SEL_CYLH:    byte_q = 8'(tf_cylinder[CYL_W-1:8]);
      SEL_HDEV:    byte_q = hdev_byte(tf_dev, tf_head);
      SEL_STCMD,
      SEL_ALTDC:   byte_q = stat;
      SEL_DRVADR:  byte_q = drive_addr_byte(tf_dev, tf_head, core_writing);
      default:     byte_q = 8'h00;
    endcase
    if (sel == SEL_DATA) host_rdata = core_rdata;
    else                 host_rdata = DW'(byte_q);
  end

  // R1: a write with both selects high leaves all task-file state alone
  p_dual_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs0 && host_cs1 && host_wr) |=>
      ($stable({tf_feature, tf_sec_count, tf_sec_index, tf_cylinder, tf_head, tf_dev})
       && !cmd_valid));

  // R8: an alternate status read keeps a pending interrupt
  p_alt_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.re_alt && irq_pending && !soft_reset) |=> irq_pending);

  // R9: the mask bit keeps the line low
  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb.we_dctl && host_wdata[1]) |-> !intrq);

endmodule

// File: tb/ata_taskfile_test.sv
`timescale 1ns/1ps
module ata_taskfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs0 = 0, host_cs1 = 0, host_rd = 0, host_wr = 0;
  logic [2:0]  host_addr = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] host_rdata;
  logic        core_busy = 0, core_ready = 0, core_drq = 0, core_err = 0;
  logic        core_wfault = 0, core_seek_ok = 0, core_corrected = 0, core_index = 0;
  logic [6:0]  core_fault_code = 7'h45;
  logic        core_writing = 0, core_done = 0;
  logic [15:0] core_rdata = 16'h0;
  logic [7:0]  tf_feature, tf_sec_count, cmd_code;
  logic [8:0]  tf_sec_index;
  logic [9:0]  tf_cylinder;
  logic [3:0]  tf_head;
  logic        tf_dev, cmd_valid, dp_rd, dp_wr, intrq, soft_reset;
  logic [15:0] dp_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ata_taskfile uut (
    .clk(clk), .rst_n(rst_n), .host_cs0(host_cs0), .host_cs1(host_cs1),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_busy(core_busy), .core_ready(core_ready), .core_drq(core_drq),
    .core_err(core_err), .core_wfault(core_wfault), .core_seek_ok(core_seek_ok),
    .core_corrected(core_corrected), .core_index(core_index),
    .core_fault_code(core_fault_code), .core_writing(core_writing),
    .core_done(core_done), .core_rdata(core_rdata),
    .tf_feature(tf_feature), .tf_sec_count(tf_sec_count),
    .tf_sec_index(tf_sec_index), .tf_cylinder(tf_cylinder), .tf_head(tf_head),
    .tf_dev(tf_dev), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata), .intrq(intrq),
    .soft_reset(soft_reset)
  );

  // {req[3:0], write, cs0, cs1, addr[2:0], data / expected[15:0]}
  localparam int NV = 20;
  localparam logic [25:0] VEC [NV] = '{
    {4'd3,  1'b1, 1'b1, 1'b0, 3'd2, 16'h0005},  // R3 sector count
    {4'd3,  1'b0, 1'b1, 1'b0, 3'd2, 16'h0005},
    {4'd1,  1'b1, 1'b1, 1'b1, 3'd2, 16'h0077},  // R1 both selects: ignored
    {4'd1,  1'b0, 1'b1, 1'b0, 3'd2, 16'h0005},
    {4'd3,  1'b1, 1'b1, 1'b0, 3'd3, 16'h0012},  // R3 sector number
    {4'd3,  1'b0, 1'b1, 1'b0, 3'd3, 16'h0012},
    {4'd3,  1'b1, 1'b1, 1'b0, 3'd4, 16'h00AB},  // R3 cylinder low
    {4'd3,  1'b0, 1'b1, 1'b0, 3'd4, 16'h00AB},
    {4'd3,  1'b1, 1'b1, 1'b0, 3'd5, 16'h00FF},  // R3 cylinder high masked
    {4'd3,  1'b0, 1'b1, 1'b0, 3'd5, 16'h0003},
    {4'd4,  1'b1, 1'b1, 1'b0, 3'd6, 16'h001C},  // R4 head C, slave
    {4'd4,  1'b0, 1'b1, 1'b0, 3'd6, 16'h00BC},
    {4'd4,  1'b1, 1'b1, 1'b0, 3'd6, 16'h00F3},  // R4 upper bits ignored
    {4'd4,  1'b0, 1'b1, 1'b0, 3'd6, 16'h00B3},
    {4'd6,  1'b1, 1'b1, 1'b0, 3'd1, 16'h0055},  // R6 feature write
    {4'd6,  1'b0, 1'b1, 1'b0, 3'd1, 16'h0045},  // R6 error code read
    {4'd12, 1'b1, 1'b0, 1'b1, 3'd7, 16'h00FF},  // R12 read-only
    {4'd12, 1'b0, 1'b0, 1'b1, 3'd7, 16'h0032},  // R12 head 3 slave
    {4'd1,  1'b0, 1'b1, 1'b1, 3'd3, 16'h0000},  // R1 both selects read 0
    {4'd1,  1'b0, 1'b0, 1'b0, 3'd3, 16'h0000}   // R1 no select read 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c0, input logic c1, input logic [2:0] a,
                        input logic [15:0] d);
    @(negedge clk);
    host_cs0 = c0; host_cs1 = c1; host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0; host_cs0 = 0; host_cs1 = 0;
  endtask

  task automatic bus_rd(input logic c0, input logic c1, input logic [2:0] a,
                        output logic [15:0] d);
    @(negedge clk);
    host_cs0 = c0; host_cs1 = c1; host_addr = a; host_rd = 1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 0; host_cs0 = 0; host_cs1 = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done = 1;
    @(negedge clk); core_done = 0;
  endtask

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    s[0] = core_err; s[1] = core_index; s[2] = core_corrected; s[3] = core_drq;
    s[4] = core_seek_ok; s[5] = core_wfault; s[6] = core_ready; s[7] = core_busy;
    return s;
  endfunction

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2 sec_count", tf_sec_count, 8'h01);
    chk("R2 sec_index", tf_sec_index, 9'd1);
    chk("R2 cylinder", tf_cylinder, 10'h0);
    chk("R2 feature", tf_feature, 8'h00);
    chk("R2 flags", {intrq, soft_reset, cmd_valid, tf_dev}, 4'b0000);
    bus_rd(1, 0, 3'd6, rv);
    chk("R2 R4 head/dev reset", rv, 16'h00A0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) bus_wr(VEC[i][20], VEC[i][19], VEC[i][18:16], VEC[i][15:0]);
      else begin
        bus_rd(VEC[i][20], VEC[i][19], VEC[i][18:16], rv);
        chk($sformatf("R%0d vector %0d", VEC[i][25:22], i), rv, VEC[i][15:0]);
      end
    end
    chk("R3 cylinder out", tf_cylinder, 10'h3AB);
    chk("R4 head/dev out", {tf_dev, tf_head}, 5'h13);
    chk("R6 feature out", tf_feature, 8'h55);
    chk("R5 sector 0x12", tf_sec_index, 9'd18);
    chk("R1 sector count kept", tf_sec_count, 8'h05);
    bus_wr(1, 0, 3'd3, 16'h0000);
    chk("R5 sector zero is 256", tf_sec_index, 9'd256);
    bus_wr(1, 0, 3'd3, 16'h00FF);
    chk("R5 sector 255", tf_sec_index, 9'd255);

    // R12 write-in-progress flag
    core_writing = 1;
    bus_rd(0, 1, 3'd7, rv);
    chk("R12 writing flag", rv, 16'h0072);
    core_writing = 0;

    // R7 status patterns
    core_ready = 1; core_seek_ok = 1; core_drq = 1; core_index = 1;
    bus_rd(1, 0, 3'd7, rv);
    chk("R7 status A", rv, {8'h00, exp_status()});
    bus_rd(0, 1, 3'd6, rv);
    chk("R7 alt status A", rv, {8'h00, exp_status()});
    core_ready = 0; core_seek_ok = 0; core_drq = 0; core_index = 0;
    core_busy = 1; core_err = 1; core_wfault = 1; core_corrected = 1;
    bus_rd(0, 1, 3'd6, rv);
    chk("R7 alt status B", rv, {8'h00, exp_status()});
    bus_rd(1, 0, 3'd7, rv);
    chk("R7 status B", rv, {8'h00, exp_status()});

    // R11 command strobe, blocked while busy
    bus_wr(1, 0, 3'd7, 16'h0020);
    chk("R11 busy write ignored", cmd_valid, 1'b0);
    core_busy = 0; core_err = 0; core_wfault = 0; core_corrected = 0;
    bus_wr(1, 0, 3'd7, 16'h00EC);
    chk("R11 strobe", {cmd_valid, cmd_code}, {1'b1, 8'hEC});
    @(negedge clk);
    chk("R11 strobe one cycle", cmd_valid, 1'b0);

    // R8 interrupt set/clear
    pulse_done();
    chk("R8 done sets", intrq, 1'b1);
    bus_rd(0, 1, 3'd6, rv);
    chk("R8 alt read keeps", intrq, 1'b1);
    bus_rd(1, 0, 3'd7, rv);
    chk("R8 status read clears", intrq, 1'b0);
    @(negedge clk);
    host_cs0 = 1; host_addr = 3'd7; host_rd = 1; core_done = 1;
    @(negedge clk);
    host_rd = 0; host_cs0 = 0; core_done = 0;
    chk("R8 done wins over read", intrq, 1'b1);
    bus_rd(1, 0, 3'd7, rv);
    chk("R8 clear after", intrq, 1'b0);

    // R9 mask
    bus_wr(0, 1, 3'd6, 16'h0002);
    pulse_done();
    chk("R9 masked", intrq, 1'b0);
    bus_wr(0, 1, 3'd6, 16'h0000);
    chk("R9 unmasked pending", intrq, 1'b1);
    bus_rd(1, 0, 3'd7, rv);

    // R10 software reset
    pulse_done();
    bus_wr(0, 1, 3'd6, 16'h0004);
    chk("R10 reset raised", soft_reset, 1'b1);
    bus_wr(1, 0, 3'd2, 16'h0009);
    chk("R10 reset held", soft_reset, 1'b1);
    pulse_done();
    chk("R10 interrupt held clear", intrq, 1'b0);
    bus_wr(0, 1, 3'd6, 16'h0000);
    chk("R10 reset released", {soft_reset, intrq}, 2'b00);

    // R13 data port
    core_rdata = 16'hBEEF;
    @(negedge clk);
    host_cs0 = 1; host_addr = 3'd0; host_rd = 1;
    #1 chk("R13 data read", {dp_rd, host_rdata}, {1'b1, 16'hBEEF});
    @(negedge clk);
    host_rd = 0; host_wr = 1; host_wdata = 16'h1234;
    #1 chk("R13 data write", {dp_wr, dp_rd, dp_wdata}, {2'b10, 16'h1234});
    @(negedge clk);
    host_wr = 0; host_cs0 = 0;
    #1 chk("R13 pulses end", {dp_wr, dp_rd}, 2'b00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule